// File: doc/BRIEF.md
# Deterministic Divided-Clock Output Gate

This block produces a set of divided clock outputs from one fast source clock and turns each of them on or off without ever emitting a shortened pulse. Each channel has its own integer divider and ratio. A channel also has a pin-level enable, a register mute bit, a mute-level select and a glitch-less mode bit. One global enable acts on every divided channel. A separate bypass output carries a reference clock straight through and ignores the global enable.

An enable request must hold its new level for four consecutive rising edges of the channel's own divided clock before it is accepted, and this applies to both rising and falling requests. The accepted state is applied only at the start of an output period, so the first and last pulses are always full width. While a channel is off, its output sits at the selected mute level. Gating is done at the divider, so a channel whose divider is switched off cannot accept enable changes.

Top module: `clk_out_gate`

## Requirements
- R1: The divider ratio is N = code + 1, where `div_m1` holds the code in an 8-bit field per channel (channel c uses bits [8c+7:8c]). Codes 0 and 1 both give N = 2. Each period starts high, with ceil(N/2) high source cycles followed by the low cycles.
- R2: The enable request passes through a two-flop synchronizer. It is accepted only when it differs from the current state on four consecutive rising edges of that channel's divided clock. A request held for fewer than four such edges has no effect.
- R3: The enable request of channel c is `pin_en[c]` AND `glob_en`.
- R4: A disabled or muted output drives `mute_lvl[c]`, where 0 gives low and 1 gives high. A change of `mute_lvl` shows on the output in the same cycle.
- R5: `mute[c]` = 1 forces the mute level whatever the enables are. When `glitchless[c]` = 0, the mute takes effect on the next source edge.
- R6: When `glitchless[c]` = 1, mute and unmute take effect only at the start of an output period, so no pulse is cut short.
- R7: An accepted enable starts the output at the beginning of a period, so the first high pulse lasts the full ceil(N/2) cycles.
- R8: While `div_on[c]` = 0, the divider is held and an enabled output stays low. Enable changes made during that time are not accepted. When the divider is restarted, it begins a full period on the next edge.
- R9: `byp_out` equals `byp_clk` while `byp_on` = 1 and is low otherwise. `glob_en` has no effect on it.
- R10: After reset every channel output is at its mute level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global enable for divided channels |
| pin_en | input | NCH | Per-channel enable request (asynchronous) |
| div_on | input | NCH | Per-channel divider run |
| mute | input | NCH | Per-channel mute force |
| mute_lvl | input | NCH | Per-channel mute level |
| glitchless | input | NCH | Per-channel period-aligned mute mode |
| div_m1 | input | NCH*DW | Per-channel ratio code (N-1) |
| byp_on | input | 1 | Bypass output enable |
| byp_clk | input | 1 | Reference clock for bypass path |
| clk_out | output | NCH | Divided, gated clock outputs |
| byp_out | output | 1 | Bypass clock output |

## Verification
A change of the mute level reaches the output in the same cycle. A mute with glitch-less mode off lands one source edge later. An enable or disable lands between 3N+3 and 4N+3 source cycles after the pin change: two synchronizer edges, up to N cycles to the first divided edge, then three more periods. The bench therefore uses a fixed cycle only where the delay is exact. Elsewhere it checks that nothing changes during the guaranteed dead window of 3N cycles, then counts rising edges and high cycles over windows that span whole periods (k·N cycles), where the counts are exact whatever the phase. Pulse widths are checked on the first pulse after enable and on the last pulse before a period-aligned mute.

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  parameter int QUAL = 4
) (
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              glob_en,
  input  logic [NCH-1:0]    pin_en,
  input  logic [NCH-1:0]    div_on,
  input  logic [NCH-1:0]    mute,
  input  logic [NCH-1:0]    mute_lvl,
  input  logic [NCH-1:0]    glitchless,
  input  logic [NCH*DW-1:0] div_m1,
  input  logic              byp_on,
  input  logic              byp_clk,
  output logic [NCH-1:0]    clk_out,
  output logic              byp_out
);
  localparam int QW = (QUAL > 2) ? $clog2(QUAL) : 1;

  logic [DW-1:0] cnt    [NCH];
  logic [DW-1:0] cnt_nx [NCH];
  logic [DW-1:0] lim    [NCH];
  logic [DW:0]   hl     [NCH];
  logic [QW-1:0] qc     [NCH];
  logic [1:0]    sy     [NCH];
  logic [NCH-1:0] en_q, mute_q, gate_q, hi_q;
  logic [NCH-1:0] wrap, diff, acc, en_nx, mute_nx, hi_nx;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      lim[c]     = (div_m1[c*DW +: DW] == '0) ? DW'(1) : div_m1[c*DW +: DW];
      hl[c]      = ({1'b0, lim[c]} + (DW+1)'(2)) >> 1;
      wrap[c]    = div_on[c] && (cnt[c] == lim[c]);
      cnt_nx[c]  = !div_on[c] ? lim[c] : (wrap[c] ? '0 : cnt[c] + DW'(1));
      hi_nx[c]   = div_on[c] && ({1'b0, cnt_nx[c]} < hl[c]);
      diff[c]    = sy[c][1] != en_q[c];
      acc[c]     = wrap[c] && diff[c] && (qc[c] == QW'(QUAL-1));
      en_nx[c]   = acc[c] ? sy[c][1] : en_q[c];
      mute_nx[c] = (glitchless[c] && !wrap[c]) ? mute_q[c] : mute[c];
    end
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        cnt[c] <= '0;
        qc[c]  <= '0;
        sy[c]  <= '0;
      end
      en_q   <= '0;
      mute_q <= '1;
      gate_q <= '0;
      hi_q   <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        cnt[c] <= cnt_nx[c];
        sy[c]  <= {sy[c][0], pin_en[c] & glob_en};
        if (wrap[c]) qc[c] <= (diff[c] && !acc[c]) ? qc[c] + QW'(1) : '0;
      end
      en_q   <= en_nx;
      mute_q <= mute_nx;
      gate_q <= en_nx & ~mute_nx;
      hi_q   <= hi_nx;
    end
  end

  assign clk_out = (gate_q & hi_q) | (~gate_q & mute_lvl);
  assign byp_out = byp_on & byp_clk;

endmodule

module clk_out_gate_chk #(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  parameter int QW   = 2,
  parameter int QUAL = 4
) (
  input logic           clk_src,
  input logic           rst_n,
  input logic [NCH-1:0] div_on,
  input logic [NCH-1:0] mute,
  input logic [NCH-1:0] glitchless,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] gate_q,
  input logic [NCH-1:0] wrap,
  input logic [QW-1:0]  qc  [NCH],
  input logic [DW-1:0]  cnt [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_QUAL_WINDOW: assert property (@(posedge clk_src) disable iff (!rst_n)
      !$stable(en_q[c]) |-> ($past(wrap[c]) && $past(qc[c]) == QW'(QUAL-1))); // R2
    AST_DIV_FREEZE: assert property (@(posedge clk_src) disable iff (!rst_n)
      !div_on[c] |=> $stable(en_q[c])); // R8
    AST_MUTE_FORCE: assert property (@(posedge clk_src) disable iff (!rst_n)
      (mute[c] && !glitchless[c]) |=> !gate_q[c]); // R5
    AST_PERIOD_ALIGN: assert property (@(posedge clk_src) disable iff (!rst_n)
      ($past(glitchless[c]) && !$stable(gate_q[c])) |-> cnt[c] == '0); // R6
  end
endmodule

bind clk_out_gate clk_out_gate_chk #(.NCH(NCH), .DW(DW), .QW(QW), .QUAL(QUAL)) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .div_on(div_on), .mute(mute),
  .glitchless(glitchless), .en_q(en_q), .gate_q(gate_q), .wrap(wrap),
  .qc(qc), .cnt(cnt)
);

// File: tb/tb_clk_out_gate.sv
`timescale 1ns/1ps
module tb_clk_out_gate;
  localparam int NCH = 4;
  localparam int DW  = 8;

  logic clk = 0, rst_n = 0, glob_en = 0, byp_on = 0, byp_clk = 0;
  logic [NCH-1:0] pin_en = '0, div_on = '1, mute = '0, mute_lvl = '0, glitchless = '0;
  logic [NCH*DW-1:0] div_m1 = {8'd2, 8'd1, 8'd5, 8'd3};
  logic [NCH-1:0] clk_out;
  logic byp_out;

  int nv[NCH] = '{4, 6, 2, 3};
  int n_chk = 0, n_err = 0;
  int rises[NCH], highs[NCH];
  bit done = 0;

  always #4 clk = ~clk;

  clk_out_gate dut (
    .clk_src(clk), .rst_n(rst_n), .glob_en(glob_en), .pin_en(pin_en),
    .div_on(div_on), .mute(mute), .mute_lvl(mute_lvl), .glitchless(glitchless),
    .div_m1(div_m1), .byp_on(byp_on), .byp_clk(byp_clk),
    .clk_out(clk_out), .byp_out(byp_out)
  );

  function automatic int hi(input int n);
    return (n + 1) / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic window(input int n);
    logic [NCH-1:0] prev;
    prev = clk_out;
    for (int c = 0; c < NCH; c++) begin rises[c] = 0; highs[c] = 0; end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (clk_out[c] && !prev[c]) rises[c]++;
        if (clk_out[c]) highs[c]++;
      end
      prev = clk_out;
    end
  endtask

  task automatic wait_rise(input int c);
    logic p;
    p = clk_out[c];
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (clk_out[c] && !p) return;
      p = clk_out[c];
    end
  endtask

  task automatic t_reset;
    mute_lvl = 4'b0101;
    rst_n = 0;
    cyc(3);
    chk(clk_out == 4'b0101, "R10 reset outputs at mute level", clk_out, 5);
    chk(byp_out == 0, "R9 bypass off", byp_out, 0);
    rst_n = 1;
    cyc(5);
    chk(clk_out == 4'b0101, "R10 outputs stay muted without enable", clk_out, 5);
    mute_lvl = '0;
    glob_en = 1;
    cyc(2);
  endtask

  task automatic t_enable;
    int first[NCH], w1[NCH], rc[NCH];
    logic [NCH-1:0] prev;
    for (int c = 0; c < NCH; c++) begin first[c] = -1; w1[c] = 0; rc[c] = 0; end
    pin_en = '1;
    prev = clk_out;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (clk_out[c] && !prev[c]) begin
          rc[c]++;
          if (first[c] < 0) first[c] = i;
        end
        if (clk_out[c] && rc[c] == 1) w1[c]++;
      end
      prev = clk_out;
    end
    for (int c = 0; c < NCH; c++) begin
      chk(first[c] >= 3*nv[c] && first[c] <= 4*nv[c]+4, "R2 enable qualified after four periods", first[c], 3*nv[c]);
      chk(w1[c] == hi(nv[c]), "R7 first pulse full width", w1[c], hi(nv[c]));
    end
    for (int c = 0; c < NCH; c++) begin
      window(6*nv[c]);
      chk(rises[c] == 6, "R1 divided edge count", rises[c], 6);
      chk(highs[c] == 6*hi(nv[c]), "R1 high time per period", highs[c], 6*hi(nv[c]));
    end
  endtask

  task automatic t_short_pulse;
    pin_en[0] = 0;
    cyc(8);
    pin_en[0] = 1;
    window(64);
    chk(rises[0] == 16, "R2 short disable request ignored", rises[0], 16);
  endtask

  task automatic t_disable;
    pin_en[1] = 0;
    window(18);
    chk(rises[1] == 3, "R2 output keeps running before qualification", rises[1], 3);
    cyc(12);
    window(18);
    chk(rises[1] == 0 && highs[1] == 0, "R2 disable accepted", highs[1], 0);
  endtask

  task automatic t_level;
    mute_lvl[1] = 1;
    #1;
    chk(clk_out[1] == 1, "R4 mute level high", clk_out[1], 1);
    mute_lvl[1] = 0;
    #1;
    chk(clk_out[1] == 0, "R4 mute level low", clk_out[1], 0);
    cyc(1);
  endtask

  task automatic t_mute_fast;
    wait_rise(0);
    mute[0] = 1;
    cyc(1);
    chk(clk_out[0] == 0, "R5 immediate mute cuts pulse", clk_out[0], 0);
    window(12);
    chk(highs[0] == 0, "R5 muted output constant", highs[0], 0);
    mute[0] = 0;
    cyc(8);
    window(16);
    chk(rises[0] == 4, "R5 unmute resumes clock", rises[0], 4);
  endtask

  task automatic t_mute_gl;
    int w;
    logic p;
    glitchless[3] = 1;
    wait_rise(3);
    mute[3] = 1;
    cyc(1);
    chk(clk_out[3] == 1, "R6 aligned mute waits for period end", clk_out[3], 1);
    cyc(6);
    window(9);
    chk(highs[3] == 0, "R6 aligned mute applied", highs[3], 0);
    cyc(1);
    mute[3] = 0;
    w = 0;
    p = clk_out[3];
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (clk_out[3] && (w > 0 || !p)) w++;
      else if (w > 0) break;
      p = clk_out[3];
    end
    chk(w == 2, "R6 first pulse after aligned unmute full width", w, 2);
    glitchless[3] = 0;
  endtask

  task automatic t_global;
    byp_on = 1;
    for (int k = 0; k < 6; k++) begin
      byp_clk = k[0];
      #1;
      chk(byp_out == byp_clk, "R9 bypass follows reference", byp_out, byp_clk);
      cyc(1);
    end
    glob_en = 0;
    cyc(40);
    window(24);
    chk(rises[0] == 0 && rises[2] == 0 && rises[3] == 0, "R3 global disable stops channels",
        rises[0] + rises[2] + rises[3], 0);
    for (int k = 0; k < 4; k++) begin
      byp_clk = ~k[0];
      #1;
      chk(byp_out == byp_clk, "R9 bypass ignores global enable", byp_out, byp_clk);
      cyc(1);
    end
    byp_on = 0;
    byp_clk = 1;
    #1;
    chk(byp_out == 0, "R9 bypass off drives low", byp_out, 0);
    glob_en = 1;
    cyc(24);
    window(16);
    chk(rises[0] == 4, "R3 global re-enable", rises[0], 4);
  endtask

  task automatic t_divoff;
    div_on[0] = 0;
    cyc(3);
    pin_en[0] = 0;
    window(30);
    chk(highs[0] == 0, "R8 stopped divider holds output low", highs[0], 0);
    pin_en[0] = 1;
    cyc(4);
    div_on[0] = 1;
    window(8);
    chk(rises[0] == 2, "R8 enable change ignored while divider stopped", rises[0], 2);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_short_pulse();
    t_disable();
    t_level();
    t_mute_fast();
    t_mute_gl();
    t_global();
    t_divoff();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule